// File: doc/BRIEF.md
# Serial receiver with error-tagged FIFO

This block turns an asynchronous serial line into a queue of received characters. The line is oversampled by a 16x tick enable that is generated elsewhere. The start edge is confirmed in the middle of the start bit. Every later bit is sampled once, at its centre. Each finished character enters a 16-entry FIFO as a 10-bit word that carries its own parity-error and frame-error flags. Software therefore sees exactly which character was damaged. A line held low for a whole frame (a break) arrives as a word with the frame-error flag set and zero data.

The frame format inputs are meant to be shared with a companion transmitter. They select the data length, the parity and the number of stop bits. A status vector reports five conditions: characters waiting, FIFO half full, the head word's error flags, a dropped character (overrun) and an idle timeout. A 9-bit mask at the same bit positions selects which status bits drive the interrupt line. A read strobe pops the head word. A flush strobe empties the FIFO. A receive enable gates reception, and a loopback select takes the line from the transmitter output instead of the pin.

The character state machine `srx_frame_rx` has six states:
- IDLE → START when a falling edge is seen (previous sample high, current sample low).
- START → IDLE if the line is high again at tick 8 (a glitch).
- START → DATA if the line is still low at tick 8.
- DATA → PAR after the last data bit in the parity formats.
- DATA → STOP after the last data bit otherwise.
- PAR → STOP after the parity bit.
- STOP → STOP2 when two stop bits are selected.
- STOP → IDLE with a push after one stop bit.
- STOP2 → IDLE with a push.
- Any state → IDLE while the receive enable is low.

Top module: `serial_rx_errfifo`

## Requirements
- R1: A received word is {frame error (bit 9), parity error (bit 8), data[7:0]}. The data arrives LSB first. With fmt_sel=2'b01 (7 data bits and a parity bit) the data fills bits 6:0 and bit 7 reads 0. With 2'b00 it is 8 data bits and no parity. With 2'b10 it is 8 data bits and a parity bit. The value 2'b11 behaves as 2'b00.
- R2: Parity is even when parity_odd=0 and odd when parity_odd=1. Bit 8 is set only in format 2'b01, and only when the received parity bit is wrong. In both 8-bit formats bit 8 always reads 0.
- R3: A stop bit sampled low sets bit 9. A break gives one word with bit 9 set and zero data. No further character starts until the line has returned high.
- R4: A low pulse that has ended by tick 8 of the start bit is discarded and produces no word.
- R5: Words leave in arrival order, and each rd_en pulse pops one word. rd_data shows the head word. Status bit 0 means non-empty. Status bit 8 means at least 8 words are stored. Status bits 3 and 4 show the head word's parity and frame flags.
- R6: A character that completes while 16 words are stored (and no pop happens in that cycle) is dropped and sets status bit 5. A pop or a flush clears bit 5.
- R7: Status bit 7 is set when the FIFO is non-empty and timeout_len character times pass with no push, pop or flush. A character time is 16 ticks times the frame length in bits. A push, pop or flush clears bit 7. timeout_len=0 disables it.
- R8: While rx_en=0 nothing is received.
- R9: A one-cycle fifo_flush empties the FIFO and clears status bits 5 and 7.
- R10: With loop_en=1 the receiver listens to tx_loop. With loop_en=0 it listens to rx_pin.
- R11: irq is the OR of status & irq_mask. Status bits 1, 2 and 6 always read 0.
- R12: With stop_two=1 both stop bits are checked, and a low second stop bit sets bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rx_pin | input | 1 | Serial line from the pin |
| tx_loop | input | 1 | Transmitter output, used in loopback |
| loop_en | input | 1 | Selects tx_loop as the line |
| rx_en | input | 1 | Receive enable |
| fmt_sel | input | 2 | Frame format, see R1 |
| parity_odd | input | 1 | Odd parity select |
| stop_two | input | 1 | Two stop bits |
| fifo_flush | input | 1 | FIFO flush strobe |
| timeout_len | input | 8 | Idle timeout in character times |
| irq_mask | input | 9 | Interrupt enable per status bit |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | 10 | Head word |
| status | output | 9 | Status vector |
| irq | output | 1 | Interrupt |

## Verification
A wrong bit counter or sampling phase in the state machine shows up as a shifted or mis-flagged word at rd_data as soon as the first character has been pushed, about one frame time after its start edge. A broken pointer or count in the FIFO surfaces at the next pop as a word out of order, or as status bits 0 and 8 disagreeing with the number of words sent. An idle timer that counts wrongly only becomes visible after timeout_len character times, so the bench checks status bit 7 both well before and well after the limit.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int WORD_W = 10;
    localparam int PE_BIT = 8;
    localparam int FE_BIT = 9;
    localparam int ST_W   = 9;

    localparam int ST_NE  = 0;
    localparam int ST_PE  = 3;
    localparam int ST_FE  = 4;
    localparam int ST_OVR = 5;
    localparam int ST_TO  = 7;
    localparam int ST_HF  = 8;

    localparam logic [1:0] FMT_8N = 2'b00;
    localparam logic [1:0] FMT_7P = 2'b01;
    localparam logic [1:0] FMT_8P = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2
    } rx_state_e;

    function automatic logic [3:0] data_bits(input logic [1:0] f);
        return (f == FMT_7P) ? 4'd7 : 4'd8;
    endfunction

    function automatic logic has_parity(input logic [1:0] f);
        return (f == FMT_7P) || (f == FMT_8P);
    endfunction

    function automatic logic [3:0] frame_bits(input logic [1:0] f, input logic two);
        return 4'd1 + data_bits(f) + {3'd0, has_parity(f)} + (two ? 4'd2 : 4'd1);
    endfunction

endpackage

// File: rtl/srx_frame_rx.sv
module srx_frame_rx
    import srx_pkg::*;
#(
    parameter int OVS = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              line_in,
    input  logic [1:0]        fmt,
    input  logic              par_odd,
    input  logic              stop_two,
    output logic              push,
    output logic [WORD_W-1:0] push_word
);
    localparam int TCW = $clog2(OVS);
    localparam logic [TCW-1:0] MID  = TCW'(OVS / 2 - 1);
    localparam logic [TCW-1:0] LAST = TCW'(OVS - 1);

    rx_state_e        state, nxt;
    logic [TCW-1:0]   tcnt;
    logic [3:0]       bidx;
    logic [7:0]       sr;
    logic             par_bit, stop_bad, prev;
    logic [3:0]       dbits;
    logic             bit_end;
    logic [7:0]       data8;
    logic             pe, fe;

    assign dbits   = data_bits(fmt);
    assign bit_end = tick && (tcnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state and push
    always_comb begin
        nxt  = state;
        push = 1'b0;
        unique case (state)
            S_IDLE:  if (tick && prev && !line_in) nxt = S_START;
            S_START: if (tick && tcnt == MID) nxt = line_in ? S_IDLE : S_DATA;
            S_DATA:  if (bit_end && bidx == dbits - 4'd1)
                         nxt = has_parity(fmt) ? S_PAR : S_STOP;
            S_PAR:   if (bit_end) nxt = S_STOP;
            S_STOP:  if (bit_end) begin
                         if (stop_two) nxt = S_STOP2;
                         else begin nxt = S_IDLE; push = 1'b1; end
                     end
            S_STOP2: if (bit_end) begin nxt = S_IDLE; push = 1'b1; end
            default: nxt = S_IDLE;
        endcase
        if (!rx_en) begin
            nxt  = S_IDLE;
            push = 1'b0;
        end
    end

    // bit timing and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt     <= '0;
            bidx     <= '0;
            sr       <= '0;
            par_bit  <= 1'b0;
            stop_bad <= 1'b0;
            prev     <= 1'b1;
        end else if (tick) begin
            prev <= line_in;
            case (state)
                S_IDLE: begin
                    tcnt <= '0;
                    bidx <= '0;
                    if (!line_in) begin
                        sr       <= '0;
                        stop_bad <= 1'b0;
                    end
                end
                S_START: tcnt <= (tcnt == MID) ? '0 : tcnt + 1'b1;
                S_DATA: begin
                    if (tcnt == LAST) begin
                        tcnt         <= '0;
                        sr[bidx[2:0]] <= line_in;
                        bidx         <= bidx + 4'd1;
                    end else tcnt <= tcnt + 1'b1;
                end
                S_PAR: begin
                    if (tcnt == LAST) begin
                        tcnt    <= '0;
                        par_bit <= line_in;
                    end else tcnt <= tcnt + 1'b1;
                end
                S_STOP: begin
                    if (tcnt == LAST) begin
                        tcnt     <= '0;
                        stop_bad <= !line_in;
                    end else tcnt <= tcnt + 1'b1;
                end
                default: tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
            endcase
        end
    end

    // word assembly
    assign data8 = (fmt == FMT_7P) ? {1'b0, sr[6:0]} : sr;
    assign pe    = (fmt == FMT_7P) && (par_bit != ((^sr[6:0]) ^ par_odd));
    assign fe    = stop_bad | !line_in;
    assign push_word = {fe, pe, data8};

    // R8
    rx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == S_IDLE));

    // R4
    glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && tick && tcnt == MID && line_in) |=> (state == S_IDLE));

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 16
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    output logic                       accepted
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          pop_ok;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign pop_ok   = pop && !empty;
    assign accepted = push && (!full || pop_ok) && !flush;
    assign rdata    = mem[rp];

    always_ff @(posedge clk) begin
        if (accepted) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (accepted) wp <= wp + 1'b1;
            if (pop_ok)   rp <= rp + 1'b1;
            count <= count + CW'(accepted) - CW'(pop_ok);
        end
    end

    // R5
    fifo_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/srx_idle_timer.sv
module srx_idle_timer #(
    parameter int OVS = 16
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       active,
    input  logic       restart,
    input  logic [3:0] frame_len,
    input  logic [7:0] limit,
    output logic       flag
);
    localparam int TCW = $clog2(OVS * 12);

    logic [TCW-1:0] tc, tc_last;
    logic [7:0]     cc;

    assign tc_last = TCW'(int'(frame_len) * OVS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc   <= '0;
            cc   <= '0;
            flag <= 1'b0;
        end else if (restart || !active) begin
            tc   <= '0;
            cc   <= '0;
            flag <= 1'b0;
        end else if (tick && !flag && limit != 8'd0) begin
            if (tc == tc_last) begin
                tc <= '0;
                cc <= cc + 8'd1;
                if (cc + 8'd1 == limit) flag <= 1'b1;
            end else begin
                tc <= tc + 1'b1;
            end
        end
    end

    // R7
    to_restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !flag);

endmodule

// File: rtl/serial_rx_errfifo.sv
module serial_rx_errfifo
    import srx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_pin,
    input  logic              tx_loop,
    input  logic              loop_en,
    input  logic              rx_en,
    input  logic [1:0]        fmt_sel,
    input  logic              parity_odd,
    input  logic              stop_two,
    input  logic              fifo_flush,
    input  logic [7:0]        timeout_len,
    input  logic [ST_W-1:0]   irq_mask,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic [ST_W-1:0]   status,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              sync1, sync2;
    logic              fr_push;
    logic [WORD_W-1:0] fr_word;
    logic [CW-1:0]     count;
    logic              full, empty, accepted, pop_eff;
    logic              ovr, to_flag;

    // line select and synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= loop_en ? tx_loop : rx_pin;
            sync2 <= sync1;
        end
    end

    srx_frame_rx #(.OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_en(rx_en),
        .line_in(sync2), .fmt(fmt_sel), .par_odd(parity_odd),
        .stop_two(stop_two), .push(fr_push), .push_word(fr_word)
    );

    assign pop_eff = rd_en && !empty;

    srx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(fr_push),
        .wdata(fr_word), .pop(rd_en), .rdata(rd_data), .count(count),
        .full(full), .empty(empty), .accepted(accepted)
    );

    srx_idle_timer #(.OVS(OVS)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .active(!empty),
        .restart(accepted || pop_eff || fifo_flush),
        .frame_len(frame_bits(fmt_sel, stop_two)),
        .limit(timeout_len), .flag(to_flag)
    );

    // overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ovr <= 1'b0;
        else if (fifo_flush)                     ovr <= 1'b0;
        else if (fr_push && full && !pop_eff)    ovr <= 1'b1;
        else if (pop_eff)                        ovr <= 1'b0;
    end

    always_comb begin
        status         = '0;
        status[ST_NE]  = !empty;
        status[ST_PE]  = !empty && rd_data[PE_BIT];
        status[ST_FE]  = !empty && rd_data[FE_BIT];
        status[ST_OVR] = ovr;
        status[ST_TO]  = to_flag;
        status[ST_HF]  = (count >= CW'(DEPTH / 2));
    end

    assign irq = |(status & irq_mask);

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_push && full && !pop_eff && !fifo_flush) |=> status[ST_OVR]);

    // R7
    to_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_flag |-> !empty);

endmodule

// File: tb/serial_rx_errfifo_tb.sv
module serial_rx_errfifo_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rx_pin = 1'b1, tx_loop = 1'b1, loop_en = 1'b0, rx_en = 1'b1;
    logic [1:0] fmt_sel = 2'b00;
    logic       parity_odd = 1'b0, stop_two = 1'b0, fifo_flush = 1'b0;
    logic [7:0] timeout_len = 8'd0;
    logic [8:0] irq_mask = 9'd0;
    logic       rd_en = 1'b0;
    logic [9:0] rd_data;
    logic [8:0] status;
    logic       irq;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    serial_rx_errfifo u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin),
        .tx_loop(tx_loop), .loop_en(loop_en), .rx_en(rx_en),
        .fmt_sel(fmt_sel), .parity_odd(parity_odd), .stop_two(stop_two),
        .fifo_flush(fifo_flush), .timeout_len(timeout_len),
        .irq_mask(irq_mask), .rd_en(rd_en), .rd_data(rd_data),
        .status(status), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input bit sel);
        if (sel) tx_loop = v; else rx_pin = v;
        repeat (16) @(negedge clk);
    endtask

    // one frame; bad_par flips parity, s1/s2 give stop levels
    task automatic send(input logic [7:0] d, input logic [1:0] f, input logic podd,
                        input logic two, input logic bad_par, input logic s1,
                        input logic s2, input bit sel);
        int nb;
        logic p;
        fmt_sel = f; parity_odd = podd; stop_two = two;
        nb = (f == 2'b01) ? 7 : 8;
        p  = ((f == 2'b01) ? ^d[6:0] : ^d) ^ podd ^ bad_par;
        @(negedge clk);
        drive_bit(1'b0, sel);
        for (int i = 0; i < nb; i++) drive_bit(d[i], sel);
        if (f == 2'b01 || f == 2'b10) drive_bit(p, sel);
        drive_bit(s1, sel);
        if (two) drive_bit(s2, sel);
        if (sel) tx_loop = 1'b1; else rx_pin = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send8(input logic [7:0] d);
        send(d, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic pop_chk(input string tag, input logic [9:0] exp);
        @(negedge clk);
        chk(tag, {22'd0, rd_data}, {22'd0, exp});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic flush;
        @(negedge clk);
        fifo_flush = 1'b1;
        @(negedge clk);
        fifo_flush = 1'b0;
    endtask

    task automatic t_reset;
        chk("R5 reset status", {23'd0, status}, 32'd0);
        chk("R11 reset irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_basic;
        send8(8'hA5);
        chk("R5 nonempty after one frame", {31'd0, status[0]}, 32'd1);
        pop_chk("R1 8N word", 10'h0A5);
        @(negedge clk);
        chk("R5 empty after pop", {31'd0, status[0]}, 32'd0);
        send8(8'h11);
        send8(8'h22);
        send(8'h80, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        pop_chk("R5 order first", 10'h011);
        pop_chk("R5 order second", 10'h022);
        pop_chk("R1 format 11 as 8N", 10'h080);
    endtask

    task automatic t_parity;
        send(8'h55, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        pop_chk("R2 7P even good", 10'h055);
        send(8'hAA, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R5 head PE status", {31'd0, status[3]}, 32'd1);
        pop_chk("R2 7P bad parity, bit7 zero", 10'h12A);
        send(8'h13, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        pop_chk("R2 7P odd good", 10'h013);
        send(8'h81, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        pop_chk("R2 8P bad parity ignored", 10'h081);
    endtask

    task automatic t_frame;
        send(8'h5A, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R3 head FE status", {31'd0, status[4]}, 32'd1);
        pop_chk("R3 bad stop", 10'h25A);
        fmt_sel = 2'b00; stop_two = 1'b0;
        @(negedge clk);
        rx_pin = 1'b0;
        repeat (16 * 14) @(negedge clk);
        rx_pin = 1'b1;
        repeat (40) @(negedge clk);
        pop_chk("R3 break word", 10'h200);
        @(negedge clk);
        chk("R3 single break word", {31'd0, status[0]}, 32'd0);
    endtask

    task automatic t_stop2;
        send(8'h3C, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        pop_chk("R12 low second stop", 10'h23C);
        send(8'hC3, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        pop_chk("R12 good two stops", 10'h0C3);
        stop_two = 1'b0;
    endtask

    task automatic t_glitch;
        @(negedge clk);
        rx_pin = 1'b0;
        repeat (5) @(negedge clk);
        rx_pin = 1'b1;
        repeat (200) @(negedge clk);
        chk("R4 glitch discarded", {31'd0, status[0]}, 32'd0);
    endtask

    task automatic t_overrun;
        for (int i = 0; i < 16; i++) begin
            send8(8'(i * 7 + 1));
            if (i == 6) chk("R5 half flag at 7", {31'd0, status[8]}, 32'd0);
            if (i == 7) chk("R5 half flag at 8", {31'd0, status[8]}, 32'd1);
        end
        chk("R6 no overrun when just full", {31'd0, status[5]}, 32'd0);
        send8(8'hEE);
        chk("R6 overrun set", {31'd0, status[5]}, 32'd1);
        pop_chk("R6 head kept", 10'h001);
        @(negedge clk);
        chk("R6 pop clears overrun", {31'd0, status[5]}, 32'd0);
        for (int i = 1; i < 16; i++) begin
            @(negedge clk);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            if (i == 14) chk("R6 last kept word", {22'd0, rd_data}, 32'(15 * 7 + 1));
        end
        @(negedge clk);
        chk("R6 dropped word absent", {31'd0, status[0]}, 32'd0);
    endtask

    task automatic t_timeout;
        timeout_len = 8'd2;
        irq_mask = 9'h080;
        send8(8'h42);
        repeat (200) @(negedge clk);
        chk("R7 no timeout early", {31'd0, status[7]}, 32'd0);
        repeat (200) @(negedge clk);
        chk("R7 timeout set", {31'd0, status[7]}, 32'd1);
        chk("R11 irq from timeout", {31'd0, irq}, 32'd1);
        pop_chk("R7 word", 10'h042);
        @(negedge clk);
        chk("R7 pop clears timeout", {31'd0, status[7]}, 32'd0);
        timeout_len = 8'd0;
        send8(8'h43);
        repeat (500) @(negedge clk);
        chk("R7 zero disables", {31'd0, status[7]}, 32'd0);
        flush();
        irq_mask = 9'd0;
    endtask

    task automatic t_flush;
        timeout_len = 8'd1;
        for (int i = 0; i < 17; i++) send8(8'(i));
        repeat (200) @(negedge clk);
        chk("R9 pre flush overrun+timeout", {30'd0, status[7], status[5]}, 32'd3);
        flush();
        @(negedge clk);
        chk("R9 flush clears status", {23'd0, status}, 32'd0);
        timeout_len = 8'd0;
    endtask

    task automatic t_disable;
        rx_en = 1'b0;
        send8(8'h77);
        chk("R8 disabled no word", {31'd0, status[0]}, 32'd0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_loop;
        loop_en = 1'b1;
        send(8'h69, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        pop_chk("R10 loopback word", 10'h069);
        send8(8'h96);
        chk("R10 pin ignored in loopback", {31'd0, status[0]}, 32'd0);
        loop_en = 1'b0;
        repeat (4) @(negedge clk);
        send(8'h5F, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R10 tx ignored without loopback", {31'd0, status[0]}, 32'd0);
    endtask

    task automatic t_irq;
        send8(8'h01);
        irq_mask = 9'h001;
        @(negedge clk);
        chk("R11 irq nonempty", {31'd0, irq}, 32'd1);
        chk("R11 reserved bits zero", {29'd0, status[6], status[2], status[1]}, 32'd0);
        irq_mask = 9'h1FE;
        @(negedge clk);
        chk("R11 irq masked", {31'd0, irq}, 32'd0);
        irq_mask = 9'd0;
        pop_chk("R11 word", 10'h001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_parity();
        t_frame();
        t_stop2();
        t_glitch();
        t_overrun();
        t_timeout();
        t_flush();
        t_disable();
        t_loop();
        t_irq();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule